// File: doc/BRIEF.md
# Refresh and DMA Hold Arbiter

This block shares the system bus between periodic DRAM refresh cycles and DMA hold requests. An interval timer's tick starts a refresh request. The request is resynchronized on a half-rate DMA clock enable and then again on the system clock, where it forms an internal refresh grant bit. The block combines the refresh request and the latched DMA hold request into a single hold request to the CPU. The CPU's hold request is suppressed while an interrupt-acknowledge cycle is running.

Once the CPU acknowledges the hold, a granted refresh drives an active-low strobe for a fixed number of ready cycles. After that, every request flop and the grant bit are cleared. The block never preempts a DMA transfer that is already running. While the DMA side holds the bus, the refresh grant cannot be set. While a refresh is running, the acknowledge forwarded to the DMA controllers is held low. All logic runs on one clock; the half-rate DMA clock is modelled as an enable input.

Top module: `refreshArbiter`

## Requirements
- R1: A 0-to-1 transition of `tmrTick` leads to `cpuHoldReq` going high within 4 clock cycles, when no interrupt acknowledge is active.
- R2: `cpuHoldReq` is the OR of the pending refresh request and `dmaHoldReq`, and it is forced to 0 whenever `intAckActive` is 1.
- R3: `refreshN` is low only while `cpuHoldReq` and `cpuHoldAck` are both 1 and a refresh has been granted. A pending refresh with `cpuHoldAck` at 0 keeps `refreshN` at 1.
- R4: With `busReady` held at 1, `refreshN` stays low for exactly STROBE_LEN (default 4) consecutive clock cycles.
- R5: Each clock cycle of the strobe during which `busReady` is 0 lengthens the strobe by one cycle.
- R6: When the strobe ends, the refresh request is cleared. With `dmaHoldReq` at 0, `cpuHoldReq` is 0 in the first cycle in which `refreshN` is high again.
- R7: While `dmaHoldReq` is 1, a new timer tick produces no strobe, and `cpuHoldReq` stays 1. After `dmaHoldReq` drops, the deferred refresh runs its full strobe.
- R8: `dmaHoldAck` is `cpuHoldAck` ANDed with a registered copy of `dmaHoldReq`. It is 0 throughout a strobe. A DMA request raised in the first strobe cycle is acknowledged no later than STROBE_LEN+1 cycles afterwards.
- R9: A synchronous active-high `rst` clears all state. In the cycle after reset, `refreshN` is 1 and `dmaHoldAck` is 0, and no refresh left pending from before the reset is performed.
- R10: Only the rising edge of `tmrTick` creates a request. A tick held high produces a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmrTick | input | 1 | Periodic tick from the interval timer |
| dmaClkEn | input | 1 | Half-rate DMA clock enable, high every second cycle |
| dmaHoldReq | input | 1 | Latched hold request from the DMA controllers |
| cpuHoldAck | input | 1 | Hold acknowledge from the CPU |
| busReady | input | 1 | Ready line; low lengthens the refresh strobe |
| intAckActive | input | 1 | Interrupt-acknowledge cycle in progress |
| cpuHoldReq | output | 1 | Combined hold request to the CPU |
| refreshN | output | 1 | Active-low refresh strobe |
| dmaHoldAck | output | 1 | Hold acknowledge forwarded to the DMA controllers |

## Verification
The checker watches several relations on every cycle:
- the strobe only appears with both hold request and acknowledge present;
- the DMA acknowledge is masked during a strobe and never appears without the CPU acknowledge;
- an interrupt acknowledge always blocks the hold request;
- the strobe never exceeds STROBE_LEN ready cycles;
- the state right after reset is idle.

Other behaviours can only be shown by the bench's scenarios, because they depend on sequences:
- exact strobe length and its lengthening by wait cycles;
- deferral of a refresh behind a running DMA transfer;
- the bounded delay of a DMA request that arrives mid-refresh;
- a single strobe for a held tick.

// File: rtl/refreshArbPkg.sv
package refreshArbPkg;

  // Strobes sent from the arbitration control to the request datapath.
  typedef struct packed {
    logic active;  // refresh strobe currently driven
    logic step;    // strobe cycle with the ready line high
    logic finish;  // last ready cycle of the strobe
  } arbStrobes_t;

endpackage

// File: rtl/refreshReqPath.sv
module refreshReqPath
  import refreshArbPkg::*;
#(
  parameter int STROBE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tmrTick,
  input  logic        dmaClkEn,
  input  arbStrobes_t strb,
  output logic        refReq,
  output logic        lastBeat
);

  localparam int CW = $clog2(STROBE_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_LEN - 1);

  logic          tickPrev;
  logic          pendFf;
  logic [CW-1:0] beatCnt;

  // Timer edge capture, then resync on the half-rate enable.
  always_ff @(posedge clk) begin
    if (rst) begin
      tickPrev <= 1'b0;
      pendFf   <= 1'b0;
      refReq   <= 1'b0;
    end else begin
      tickPrev <= tmrTick;
      if (strb.finish)
        pendFf <= 1'b0;
      else if (tmrTick && !tickPrev)
        pendFf <= 1'b1;
      if (strb.finish)
        refReq <= 1'b0;
      else if (dmaClkEn)
        refReq <= pendFf;
    end
  end

  // Counts ready cycles of the strobe.
  always_ff @(posedge clk) begin
    if (rst || strb.finish)
      beatCnt <= '0;
    else if (strb.step)
      beatCnt <= beatCnt + 1'b1;
  end

  assign lastBeat = (beatCnt == LAST);

endmodule

// File: rtl/refreshCtl.sv
module refreshCtl
  import refreshArbPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        refReq,
  input  logic        lastBeat,
  input  logic        dmaHoldReq,
  input  logic        cpuHoldAck,
  input  logic        busReady,
  input  logic        intAckActive,
  output arbStrobes_t strb,
  output logic        cpuHoldReq,
  output logic        refreshN,
  output logic        dmaHoldAck
);

  logic grantBit;
  logic dmaSide;
  logic setGrant;

  assign cpuHoldReq  = (refReq | dmaHoldReq) & ~intAckActive;
  assign strb.active = cpuHoldReq & cpuHoldAck & grantBit;
  assign strb.step   = strb.active & busReady;
  assign strb.finish = strb.step & lastBeat;
  assign refreshN    = ~strb.active;
  assign dmaHoldAck  = cpuHoldAck & dmaSide;

  // The grant is blocked while the DMA side owns the bus.
  assign setGrant = refReq & ~dmaSide & ~grantBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      grantBit <= 1'b0;
      dmaSide  <= 1'b0;
    end else begin
      if (strb.finish)
        grantBit <= 1'b0;
      else if (setGrant)
        grantBit <= 1'b1;
      // The DMA side is held at 0 while a refresh is granted or being granted.
      dmaSide <= dmaHoldReq & ~grantBit & ~setGrant;
    end
  end

endmodule

// File: rtl/refreshArbiter.sv
module refreshArbiter
  import refreshArbPkg::*;
#(
  parameter int STROBE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tmrTick,
  input  logic dmaClkEn,
  input  logic dmaHoldReq,
  input  logic cpuHoldAck,
  input  logic busReady,
  input  logic intAckActive,
  output logic cpuHoldReq,
  output logic refreshN,
  output logic dmaHoldAck
);

  arbStrobes_t strb;
  logic        refReq;
  logic        lastBeat;

  refreshReqPath #(.STROBE_LEN(STROBE_LEN)) uPath (
    .clk      (clk),
    .rst      (rst),
    .tmrTick  (tmrTick),
    .dmaClkEn (dmaClkEn),
    .strb     (strb),
    .refReq   (refReq),
    .lastBeat (lastBeat)
  );

  refreshCtl uCtl (
    .clk          (clk),
    .rst          (rst),
    .refReq       (refReq),
    .lastBeat     (lastBeat),
    .dmaHoldReq   (dmaHoldReq),
    .cpuHoldAck   (cpuHoldAck),
    .busReady     (busReady),
    .intAckActive (intAckActive),
    .strb         (strb),
    .cpuHoldReq   (cpuHoldReq),
    .refreshN     (refreshN),
    .dmaHoldAck   (dmaHoldAck)
  );

endmodule

// File: rtl/refreshArbChecker.sv
module refreshArbChecker #(
  parameter int STROBE_LEN = 4
) (
  input logic clk,
  input logic rst,
  input logic busReady,
  input logic intAckActive,
  input logic cpuHoldAck,
  input logic cpuHoldReq,
  input logic refreshN,
  input logic dmaHoldAck
);

  localparam int CW = $clog2(STROBE_LEN + 2) + 1;

  logic [CW-1:0] readyLow;

  // Ready cycles seen in the current strobe.
  always_ff @(posedge clk) begin
    if (rst || refreshN)
      readyLow <= '0;
    else if (busReady)
      readyLow <= readyLow + 1'b1;
  end

  assert_strobe_needs_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !refreshN |-> (cpuHoldReq && cpuHoldAck));

  assert_dma_masked_R8: assert property (@(posedge clk) disable iff (rst)
    !refreshN |-> !dmaHoldAck);

  assert_ack_needs_cpu_R8: assert property (@(posedge clk) disable iff (rst)
    dmaHoldAck |-> cpuHoldAck);

  assert_intack_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    intAckActive |-> !cpuHoldReq);

  assert_strobe_len_R4: assert property (@(posedge clk) disable iff (rst)
    readyLow <= CW'(STROBE_LEN));

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (refreshN && !dmaHoldAck));

endmodule

bind refreshArbiter refreshArbChecker #(.STROBE_LEN(STROBE_LEN)) uChk (
  .clk          (clk),
  .rst          (rst),
  .busReady     (busReady),
  .intAckActive (intAckActive),
  .cpuHoldAck   (cpuHoldAck),
  .cpuHoldReq   (cpuHoldReq),
  .refreshN     (refreshN),
  .dmaHoldAck   (dmaHoldAck)
);

// File: tb/sim_refreshArbiter.sv
`timescale 1ns/1ps
module sim_refreshArbiter;

  localparam int LEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmrTick = 1'b0;
  logic dmaClkEn = 1'b0;
  logic dmaHoldReq = 1'b0;
  logic cpuHoldAck = 1'b0;
  logic busReady = 1'b1;
  logic intAckActive = 1'b0;
  logic cpuHoldReq, refreshN, dmaHoldAck;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) dmaClkEn <= rst ? 1'b0 : ~dmaClkEn;

  refreshArbiter #(.STROBE_LEN(LEN)) u0 (
    .clk(clk), .rst(rst), .tmrTick(tmrTick), .dmaClkEn(dmaClkEn),
    .dmaHoldReq(dmaHoldReq), .cpuHoldAck(cpuHoldAck), .busReady(busReady),
    .intAckActive(intAckActive), .cpuHoldReq(cpuHoldReq),
    .refreshN(refreshN), .dmaHoldAck(dmaHoldAck)
  );

  // {dmaHoldReq, cpuHoldAck, intAckActive, expected cpuHoldReq, expected dmaHoldAck}
  localparam logic [4:0] VEC [8] = '{
    5'b000_0_0, 5'b100_1_0, 5'b110_1_1, 5'b111_0_1,
    5'b101_0_0, 5'b010_0_0, 5'b011_0_0, 5'b001_0_0
  };

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; tmrTick = 0; dmaHoldReq = 0; cpuHoldAck = 0; busReady = 1; intAckActive = 0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  // Counts low cycles of the next strobe; optionally pulls ready low for holdCycles.
  task automatic measureLow(input int holdCycles, output int lowCount);
    int hold = 0;
    lowCount = 0;
    #1;
    for (int i = 0; i < 80; i++) begin
      if (!refreshN) begin
        lowCount++;
        if (lowCount == 1 && holdCycles > 0) begin busReady = 1'b0; hold = holdCycles; end
      end else if (lowCount > 0) begin
        break;
      end
      @(posedge clk); #1;
      if (hold > 0) begin hold--; if (hold == 0) busReady = 1'b1; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int n;
    int seen;
    doReset();
    // R9: reset state
    chk("R9", "refreshN after reset", refreshN, 1);
    chk("R9", "cpuHoldReq after reset", cpuHoldReq, 0);
    chk("R9", "dmaHoldAck after reset", dmaHoldAck, 0);

    // R2 and R8 vector table, no refresh pending
    for (int v = 0; v < 8; v++) begin
      dmaHoldReq = VEC[v][4]; cpuHoldAck = VEC[v][3]; intAckActive = VEC[v][2];
      cyc(2);
      chk("R2", $sformatf("cpuHoldReq vec%0d", v), cpuHoldReq, VEC[v][1]);
      chk("R8", $sformatf("dmaHoldAck vec%0d", v), dmaHoldAck, VEC[v][0]);
    end
    dmaHoldReq = 0; cpuHoldAck = 0; intAckActive = 0;
    cyc(3);

    // Idle bus refresh; tick stays high to show edge-only capture (R10)
    tmrTick = 1;
    seen = 0;
    for (int i = 0; i < 4; i++) begin cyc(1); if (cpuHoldReq) seen = 1; end
    chk("R1", "cpuHoldReq after tick", seen, 1);
    cyc(3);
    chk("R3", "no strobe without CPU ack", refreshN, 1);
    cpuHoldAck = 1;
    measureLow(0, n);
    chk("R4", "strobe length", n, LEN);
    chk("R6", "cpuHoldReq cleared at strobe end", cpuHoldReq, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin cyc(1); if (!refreshN) seen = 1; end
    chk("R10", "held tick gives one strobe", seen, 0);
    tmrTick = 0;
    cyc(2);

    // Ready line lengthens strobe (R5)
    tmrTick = 1; cyc(1); tmrTick = 0;
    measureLow(3, n);
    chk("R5", "strobe length with 3 wait cycles", n, LEN + 3);
    cyc(3);

    // Refresh deferred behind a running DMA transfer (R7)
    dmaHoldReq = 1;
    cyc(3);
    chk("R8", "dmaHoldAck follows DMA request", dmaHoldAck, 1);
    tmrTick = 1; cyc(1); tmrTick = 0;
    seen = 0;
    for (int i = 0; i < 12; i++) begin cyc(1); if (!refreshN || !cpuHoldReq) seen = 1; end
    chk("R7", "no strobe and hold kept during DMA", seen, 0);
    dmaHoldReq = 0;
    measureLow(0, n);
    chk("R7", "deferred strobe length", n, LEN);
    chk("R6", "cpuHoldReq cleared after deferred strobe", cpuHoldReq, 0);
    cyc(3);

    // DMA request arriving during a refresh (R8)
    tmrTick = 1; cyc(1); tmrTick = 0;
    for (int i = 0; i < 10 && refreshN; i++) cyc(1);
    chk("R3", "strobe started with CPU ack", refreshN, 0);
    dmaHoldReq = 1;
    seen = 0; n = 0;
    for (int i = 0; i < 12 && !dmaHoldAck; i++) begin
      if (!refreshN && dmaHoldAck) seen = 1;
      cyc(1); n++;
    end
    chk("R8", "ack masked during strobe", seen, 0);
    chk("R8", "DMA ack within STROBE_LEN+1", (n <= LEN + 1 && dmaHoldAck) ? 1 : 0, 1);
    chk("R2", "cpuHoldReq held by DMA", cpuHoldReq, 1);
    dmaHoldReq = 0;
    cyc(3);

    // Reset in the middle of a strobe (R9)
    tmrTick = 1; cyc(1); tmrTick = 0;
    for (int i = 0; i < 10 && refreshN; i++) cyc(1);
    rst = 1; cyc(2); rst = 0; cyc(1);
    chk("R9", "refreshN after mid-strobe reset", refreshN, 1);
    chk("R9", "cpuHoldReq after mid-strobe reset", cpuHoldReq, 0);
    seen = 0;
    for (int i = 0; i < 15; i++) begin cyc(1); if (!refreshN) seen = 1; end
    chk("R9", "pending refresh dropped by reset", seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule